// File: doc/BRIEF.md
# SR-IOV Capability Register Controller

This block is the register window for the single-root I/O virtualization extended capability of a PCIe physical function. A configuration access port carries dword reads and writes with byte enables. Only accesses whose dword address falls inside the 16-dword capability window are decoded. The window holds the VF control word and the requested VF count. It also holds the read-only VF counts, routing offset, stride and device ID, the supported and system page sizes, and six VF base address registers, each of which has a write mask fixed by a size parameter.

From the VF Enable transitions the block keeps a count of active virtual functions. It drives this count, together with a thermometer-coded enable vector (one bit per possible VF), to the logic that instantiates the VFs. Enumerating the VFs, decoding their memory and the function's own config header are all handled elsewhere.

Top module: `sriov_cap_regs`

## Requirements
- R1: In the control word (dword 2, bits 15:0), only bit 0 (VF enable), bit 3 (VF memory enable) and bit 4 (ARI hierarchy) accept writes. All other control bits, and the status half in bits 31:16, read as zero.
- R2: The requested VF count (dword 4, bits 15:0) is writable in all 16 bits, and each byte is updated only when its byte enable is set.
- R3: Initial VFs and total VFs are read-only parameter values at dword 3 (bits 15:0 and 31:16). VF offset and stride are read-only at dword 5 (bits 15:0 and 31:16). The VF device ID is read-only at dword 6, bits 31:16.
- R4: Supported page sizes (dword 7) read as 0x553 OR-ed with the optional-size parameter. System page size (dword 8) resets to 0x1, and a write changes only the bits that are in the supported set.
- R5: When a write sets bit 0 of the control word and no VFs are active, the active count becomes the requested count, provided that count is no greater than the total. Enable vector bit i is then 1 exactly when i is below the active count.
- R6: If the requested count exceeds the total when VF enable is set, the active count stays zero. The enable bit is still stored.
- R7: A control write with bit 0 clear (byte 0 enabled) returns the active count and every enable bit to zero.
- R8: The active count does not change when a control write keeps VF enable set while VFs are active, and it does not change on a requested-count write.
- R9: Writes to dword addresses below the window base, or at base+16 and above, change no register and no output.
- R10: A VF BAR (dwords 9 to 14) keeps only the write bits in ~(size-1), with bits 3:0 forced to its type code. The dword after a 64-bit memory BAR takes the upper half of the 64-bit mask and has type bits of zero. A size of zero makes a BAR read-only zero.
- R11: Reset clears control, the requested count and the active count. It returns the system page size to 0x1 and reloads each BAR with only its type bits.
- R12: A read strobe returns data on the next clock edge. Data read outside the window is zero, and a read in the same cycle as a write to the same dword returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_rd | input | 1 | Config read strobe |
| cfg_addr | input | 10 | Config dword address (byte address bits 11:2) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| active_vfs | output | 16 | Number of enabled VFs |
| vf_enable | output | VF_TOTAL | Per-VF enable, thermometer coded |

## Verification
A read and a write can land in the same cycle. The bench provokes this by raising both strobes toward the control dword in one cycle. The write sets VF enable, and the read is expected to return the old zero value while the active count rises to the requested count on the same edge. A second check targets out-of-window addresses whose distance from the base aliases the control dword in its low four bits. Writes there must leave both the control word and the active count unchanged.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;

  localparam int unsigned CAP_DWORDS = 16;
  localparam int unsigned N_VF_BARS  = 6;

  localparam logic [3:0] IDX_CTRL   = 4'd2;
  localparam logic [3:0] IDX_COUNTS = 4'd3;
  localparam logic [3:0] IDX_REQ    = 4'd4;
  localparam logic [3:0] IDX_ROUTE  = 4'd5;
  localparam logic [3:0] IDX_DEVID  = 4'd6;
  localparam logic [3:0] IDX_SUPPG  = 4'd7;
  localparam logic [3:0] IDX_SYSPG  = 4'd8;
  localparam logic [3:0] IDX_BAR0   = 4'd9;

  localparam logic [15:0] CTRL_WMASK   = 16'h0019;
  localparam logic [31:0] PG_MANDATORY = 32'h0000_0553;
  localparam logic [31:0] SYSPG_RESET  = 32'h0000_0001;

  function automatic logic is_mem64(input logic [3:0] t);
    return (!t[0]) && (t[2:1] == 2'b10);
  endfunction

  function automatic logic [31:0] bar_mask(input logic [5:0] lg, input logic upper);
    logic [63:0] m;
    if (lg == 6'd0) return 32'h0;
    m = ~((64'd1 << lg) - 64'd1);
    return upper ? m[63:32] : (m[31:0] & 32'hFFFF_FFF0);
  endfunction

  function automatic logic [31:0] be_expand(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/sriov_rst_sync.sv
module sriov_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/sriov_vf_ctrl.sv
module sriov_vf_ctrl
  import sriov_cap_pkg::*;
#(
  parameter int unsigned VF_TOTAL = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic                req_we,
  input  logic [1:0]          be,
  input  logic [15:0]         wdata,
  output logic [15:0]         ctrl_q,
  output logic [15:0]         req_q,
  output logic [15:0]         active_q,
  output logic [VF_TOTAL-1:0] enable_vec
);
  localparam logic [15:0] TOTAL16 = 16'(VF_TOTAL);

  logic [15:0] ctrl_d, req_d, active_d, byte_m;
  logic        vfe_wr, vfe_val;

  assign byte_m  = {{8{be[1]}}, {8{be[0]}}};
  assign vfe_wr  = ctrl_we && be[0];
  assign vfe_val = wdata[0];

  always_comb begin
    ctrl_d   = ctrl_q;
    req_d    = req_q;
    active_d = active_q;
    if (ctrl_we)
      ctrl_d = ((ctrl_q & ~byte_m) | (wdata & byte_m)) & CTRL_WMASK;
    if (req_we)
      req_d = (req_q & ~byte_m) | (wdata & byte_m);
    if (vfe_wr) begin
      if (active_q != 16'd0) begin
        if (!vfe_val) active_d = 16'd0;
      end else if (vfe_val && (req_q <= TOTAL16)) begin
        active_d = req_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= 16'd0;
      req_q    <= 16'd0;
      active_q <= 16'd0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (req_we)  req_q  <= req_d;
      if (vfe_wr)  active_q <= active_d;
    end
  end

  for (genvar i = 0; i < VF_TOTAL; i++) begin : g_en
    assign enable_vec[i] = (active_q > 16'(i));
  end
endmodule

// File: rtl/sriov_pgsize.sv
module sriov_pgsize
  import sriov_cap_pkg::*;
#(
  parameter logic [31:0] PG_OPTIONAL = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_we,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] sup_pg,
  output logic [31:0] sys_pg
);
  localparam logic [31:0] SUP_SET = PG_MANDATORY | PG_OPTIONAL;

  logic [31:0] sys_d, wm;

  assign sup_pg = SUP_SET;
  assign wm     = be_expand(be) & SUP_SET;

  always_comb begin
    sys_d = sys_pg;
    if (sys_we) sys_d = (sys_pg & ~wm) | (wdata & wm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sys_pg <= SYSPG_RESET;
    else if (sys_we) sys_pg <= sys_d;
  end
endmodule

// File: rtl/sriov_bar_bank.sv
module sriov_bar_bank
  import sriov_cap_pkg::*;
#(
  parameter logic [5:0][3:0] BAR_TYPE      = '0,
  parameter logic [5:0][5:0] BAR_SIZE_LOG2 = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       bar_we,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [5:0][31:0] bar_rd
);
  for (genvar i = 0; i < N_VF_BARS; i++) begin : g_bar
    localparam int unsigned PREV  = (i == 0) ? 0 : i - 1;
    localparam logic        UPPER = (i != 0) && is_mem64(BAR_TYPE[PREV]);
    localparam logic [5:0]  LG    = UPPER ? BAR_SIZE_LOG2[PREV] : BAR_SIZE_LOG2[i];
    localparam logic [31:0] MASK  = bar_mask(LG, UPPER);
    localparam logic [31:0] TYPEV = UPPER ? 32'h0 : {28'h0, BAR_TYPE[i]};

    logic [31:0] addr_q, addr_d, wm;

    assign wm = be_expand(be) & MASK;

    always_comb begin
      addr_d = addr_q;
      if (bar_we[i]) addr_d = (addr_q & ~wm) | (wdata & wm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q <= 32'h0;
      else if (bar_we[i]) addr_q <= addr_d;
    end

    assign bar_rd[i] = addr_q | TYPEV;
  end
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_cap_pkg::*;
#(
  parameter logic [11:0]     CAP_BASE        = 12'h160,
  parameter int unsigned     VF_TOTAL        = 8,
  parameter logic [15:0]     VF_INITIAL      = 16'd8,
  parameter logic [15:0]     VF_FIRST_OFFSET = 16'd1,
  parameter logic [15:0]     VF_STRIDE       = 16'd2,
  parameter logic [15:0]     VF_DEVICE_ID    = 16'h10F1,
  parameter logic [31:0]     PG_OPTIONAL     = 32'h0000_0004,
  parameter logic [5:0][3:0] BAR_TYPE        = {4'h8, 4'h0, 4'h1, 4'h0, 4'h0, 4'hC},
  parameter logic [5:0][5:0] BAR_SIZE_LOG2   = {6'd16, 6'd0, 6'd8, 6'd12, 6'd0, 6'd20}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [9:0]          cfg_addr,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [15:0]         active_vfs,
  output logic [VF_TOTAL-1:0] vf_enable
);
  localparam logic [10:0] BASE_DW = 11'(CAP_BASE >> 2);
  localparam logic [15:0] TOTAL16 = 16'(VF_TOTAL);

  logic             rst_n_s;
  logic [10:0]      rel;
  logic             in_win;
  logic [3:0]       idx;
  logic             wr_hit;
  logic [15:0]      ctrl_q, req_q;
  logic [31:0]      sup_pg, sys_pg;
  logic [5:0][31:0] bar_rd;
  logic [5:0]       bar_we;
  logic [31:0]      mux_d, rdata_d;

  sriov_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  assign rel    = {1'b0, cfg_addr} - BASE_DW;
  assign in_win = (rel < 11'(CAP_DWORDS));
  assign idx    = rel[3:0];
  assign wr_hit = cfg_wr && in_win;

  for (genvar b = 0; b < N_VF_BARS; b++) begin : g_bwe
    assign bar_we[b] = wr_hit && (idx == IDX_BAR0 + 4'(b));
  end

  sriov_vf_ctrl #(.VF_TOTAL(VF_TOTAL)) u_vf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ctrl_we   (wr_hit && (idx == IDX_CTRL)),
    .req_we    (wr_hit && (idx == IDX_REQ)),
    .be        (cfg_be[1:0]),
    .wdata     (cfg_wdata[15:0]),
    .ctrl_q    (ctrl_q),
    .req_q     (req_q),
    .active_q  (active_vfs),
    .enable_vec(vf_enable)
  );

  sriov_pgsize #(.PG_OPTIONAL(PG_OPTIONAL)) u_pg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .sys_we(wr_hit && (idx == IDX_SYSPG)),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .sup_pg(sup_pg),
    .sys_pg(sys_pg)
  );

  sriov_bar_bank #(.BAR_TYPE(BAR_TYPE), .BAR_SIZE_LOG2(BAR_SIZE_LOG2)) u_bar (
    .clk   (clk),
    .rst_n (rst_n_s),
    .bar_we(bar_we),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .bar_rd(bar_rd)
  );

  always_comb begin
    unique case (idx)
      IDX_CTRL:   mux_d = {16'h0, ctrl_q};
      IDX_COUNTS: mux_d = {TOTAL16, VF_INITIAL};
      IDX_REQ:    mux_d = {16'h0, req_q};
      IDX_ROUTE:  mux_d = {VF_STRIDE, VF_FIRST_OFFSET};
      IDX_DEVID:  mux_d = {VF_DEVICE_ID, 16'h0};
      IDX_SUPPG:  mux_d = sup_pg;
      IDX_SYSPG:  mux_d = sys_pg;
      4'd9:       mux_d = bar_rd[0];
      4'd10:      mux_d = bar_rd[1];
      4'd11:      mux_d = bar_rd[2];
      4'd12:      mux_d = bar_rd[3];
      4'd13:      mux_d = bar_rd[4];
      4'd14:      mux_d = bar_rd[5];
      default:    mux_d = 32'h0;
    endcase
  end

  always_comb begin
    rdata_d = cfg_rdata;
    if (cfg_rd) rdata_d = in_win ? mux_d : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cfg_rdata <= 32'h0;
    else if (cfg_rd) cfg_rdata <= rdata_d;
  end
endmodule

// File: rtl/sriov_cap_regs_chk.sv
module sriov_cap_regs_chk #(
  parameter logic [11:0] CAP_BASE = 12'h160,
  parameter int unsigned VF_TOTAL = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_wr,
  input logic                cfg_rd,
  input logic [9:0]          cfg_addr,
  input logic                cfg_be0,
  input logic                cfg_wdata0,
  input logic [31:0]         cfg_rdata,
  input logic [15:0]         active_vfs,
  input logic [VF_TOTAL-1:0] vf_enable
);
  localparam logic [10:0] BASE_DW = 11'(CAP_BASE >> 2);

  logic [10:0] rel;
  logic        in_win, ctrl_hit;

  assign rel      = {1'b0, cfg_addr} - BASE_DW;
  assign in_win   = (rel < 11'd16);
  assign ctrl_hit = in_win && (rel[3:0] == 4'd2);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_vfs <= 16'(VF_TOTAL));

  a_r5_vector_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vf_enable) == int'(active_vfs));

  a_r7_disable_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && ctrl_hit && cfg_be0 && !cfg_wdata0) |=> (active_vfs == 16'd0));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(active_vfs));

  a_r9_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !in_win) |=> $stable(active_vfs));

  a_r12_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !in_win) |=> (cfg_rdata == 32'h0));
endmodule

bind sriov_cap_regs sriov_cap_regs_chk #(.CAP_BASE(CAP_BASE), .VF_TOTAL(VF_TOTAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_rd    (cfg_rd),
  .cfg_addr  (cfg_addr),
  .cfg_be0   (cfg_be[0]),
  .cfg_wdata0(cfg_wdata[0]),
  .cfg_rdata (cfg_rdata),
  .active_vfs(active_vfs),
  .vf_enable (vf_enable)
);

// File: tb/sriov_cap_regs_test.sv
module sriov_cap_regs_test;
  localparam logic [9:0] BASE = 10'h058;
  localparam int NV = 28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [9:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [15:0] active_vfs;
  logic [7:0]  vf_enable;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sriov_cap_regs uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .active_vfs(active_vfs), .vf_enable(vf_enable)
  );

  // {req, idx, be, wdata, expected read, expected active}
  localparam logic [91:0] VEC [NV] = '{
    {4'd1,  4'd2,  4'hF, 32'hFFFF_FFFF, 32'h0000_0019, 16'd0}, // R1 writable bits only
    {4'd7,  4'd2,  4'h1, 32'h0000_0000, 32'h0000_0000, 16'd0}, // R7
    {4'd2,  4'd4,  4'h3, 32'hABCD_0005, 32'h0000_0005, 16'd0}, // R2
    {4'd2,  4'd4,  4'h2, 32'h0000_0700, 32'h0000_0705, 16'd0}, // R2 upper byte only
    {4'd2,  4'd4,  4'h1, 32'h0000_0003, 32'h0000_0703, 16'd0}, // R2 lower byte only
    {4'd6,  4'd2,  4'h1, 32'h0000_0001, 32'h0000_0001, 16'd0}, // R6 request over total
    {4'd6,  4'd2,  4'h1, 32'h0000_0000, 32'h0000_0000, 16'd0}, // R6
    {4'd2,  4'd4,  4'h3, 32'h0000_0006, 32'h0000_0006, 16'd0}, // R2
    {4'd5,  4'd2,  4'h1, 32'h0000_0009, 32'h0000_0009, 16'd6}, // R5 enable six
    {4'd8,  4'd4,  4'h3, 32'h0000_0002, 32'h0000_0002, 16'd6}, // R8 count write while on
    {4'd8,  4'd2,  4'h1, 32'h0000_0011, 32'h0000_0011, 16'd6}, // R8 enable kept set
    {4'd7,  4'd2,  4'h1, 32'h0000_0010, 32'h0000_0010, 16'd0}, // R7 disable
    {4'd2,  4'd4,  4'h3, 32'h0000_0008, 32'h0000_0008, 16'd0}, // R2
    {4'd5,  4'd2,  4'h1, 32'h0000_0001, 32'h0000_0001, 16'd8}, // R5 equal to total
    {4'd3,  4'd3,  4'hF, 32'hFFFF_FFFF, 32'h0008_0008, 16'd8}, // R3 counts
    {4'd3,  4'd5,  4'hF, 32'hFFFF_FFFF, 32'h0002_0001, 16'd8}, // R3 offset/stride
    {4'd3,  4'd6,  4'hF, 32'hFFFF_FFFF, 32'h10F1_0000, 16'd8}, // R3 device id
    {4'd4,  4'd7,  4'hF, 32'hFFFF_FFFF, 32'h0000_0557, 16'd8}, // R4 supported
    {4'd4,  4'd8,  4'hF, 32'hFFFF_FFFF, 32'h0000_0557, 16'd8}, // R4 system masked
    {4'd4,  4'd8,  4'hF, 32'h0000_0004, 32'h0000_0004, 16'd8}, // R4 optional size
    {4'd10, 4'd9,  4'hF, 32'hFFFF_FFFF, 32'hFFF0_000C, 16'd8}, // R10 64-bit lower
    {4'd10, 4'd10, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd8}, // R10 64-bit upper
    {4'd10, 4'd11, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_F000, 16'd8}, // R10 32-bit
    {4'd10, 4'd12, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FF01, 16'd8}, // R10 I/O
    {4'd10, 4'd13, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 16'd8}, // R10 unused
    {4'd10, 4'd14, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_0008, 16'd8}, // R10 prefetch 32-bit
    {4'd10, 4'd9,  4'h4, 32'h0000_0000, 32'hFF00_000C, 16'd8}, // R10 byte enable
    {4'd7,  4'd2,  4'h1, 32'h0000_0000, 32'h0000_0000, 16'd0}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    v = cfg_rdata;
  endtask

  function automatic logic [7:0] therm(input logic [15:0] n);
    logic [7:0] t = '0;
    for (int i = 0; i < 8; i++) if (16'(i) < n) t[i] = 1'b1;
    return t;
  endfunction

  task automatic check_reset_state(input string tag);
    logic [31:0] v;
    check({tag, " R11 active"}, {16'h0, active_vfs}, 32'h0);
    check({tag, " R11 vector"}, {24'h0, vf_enable}, 32'h0);
    rd(BASE + 10'd2, v);  check({tag, " R11 ctrl"}, v, 32'h0);
    rd(BASE + 10'd4, v);  check({tag, " R11 request"}, v, 32'h0);
    rd(BASE + 10'd8, v);  check({tag, " R11 sys page"}, v, 32'h1);
    rd(BASE + 10'd9, v);  check({tag, " R11 bar0 type"}, v, 32'hC);
    rd(BASE + 10'd10, v); check({tag, " R11 bar1 upper"}, v, 32'h0);
    rd(BASE + 10'd12, v); check({tag, " R11 bar3 type"}, v, 32'h1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
    cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    check("R12 rdata in reset", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("initial");

    for (int k = 0; k < NV; k++) begin
      logic [91:0] e;
      string tag;
      e = VEC[k];
      tag = $sformatf("R%0d vec%0d", e[91:88], k);
      wr(BASE + 10'(e[87:84]), e[83:80], e[79:48]);
      check({tag, " active"}, {16'h0, active_vfs}, {16'h0, e[15:0]});
      check({tag, " vector"}, {24'h0, vf_enable}, {24'h0, therm(e[15:0])});
      rd(BASE + 10'(e[87:84]), v);
      check({tag, " read"}, v, e[47:16]);
    end

    // R9: out-of-window addresses aliasing the control dword; request is 8
    wr(BASE + 10'd18, 4'hF, 32'hFFFF_FFFF);
    wr(BASE - 10'd14, 4'hF, 32'hFFFF_FFFF);
    check("R9 active unchanged", {16'h0, active_vfs}, 32'h0);
    rd(BASE + 10'd2, v);
    check("R9 ctrl unchanged", v, 32'h0);

    // R12: outside read returns zero after a nonzero read
    rd(BASE + 10'd9, v);
    check("R12 bar0 readback", v, 32'hFF00_000C);
    rd(BASE + 10'd18, v);
    check("R12 outside read zero", v, 32'h0);

    // R12 with R5: read and write to control in the same cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_addr = BASE + 10'd2;
    cfg_be = 4'h1; cfg_wdata = 32'h19;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    check("R12 same-cycle read old value", cfg_rdata, 32'h0);
    check("R5 same-cycle enable", {16'h0, active_vfs}, 32'd8);
    rd(BASE + 10'd2, v);
    check("R12 read after write", v, 32'h19);

    // R11: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async active clear", {16'h0, active_vfs}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("midrun");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule